// File: doc/BRIEF.md
# Modem Status Register with Internal Loopback

This block holds the modem status byte of a serial port. It watches four active-low modem handshake inputs (clear-to-send, data-set-ready, ring indicator and carrier detect). In the upper nibble of its status byte it shows the asserted level of each input. In the lower nibble it keeps sticky change flags, which remember that an input has moved since the host last read the byte.

The pins are asynchronous to the block clock, so they pass through a synchronizer before they are used. When the host reads the byte it pulses a read strobe, and that strobe clears the change flags. In internal loopback mode the pins are disconnected from the status byte. Each status bit then follows one of the port's own modem control outputs, so software can exercise the status path without a cable.

The delta logic always compares the current effective source with the value it held one cycle earlier. Switching the loopback mode can therefore raise flags by itself.

Top module: `modem_status_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the change flags `status[3:0]` clear to 0, and the previous-value state loads from the current effective inputs. After reset with steady pins, `status` equals `{~dcd_n, ~ri_n, ~dsr_n, ~cts_n, 4'b0000}` and no flag rises afterwards.
- R2: With `loop_en` low, `status[4]`, `status[5]`, `status[6]` and `status[7]` are the complements of `cts_n`, `dsr_n`, `ri_n` and `dcd_n`. A pin change shows there after exactly two rising clock edges.
- R3: With `loop_en` low, a change in either direction of `cts_n`, `dsr_n` or `dcd_n` sets `status[0]`, `status[1]` or `status[3]` respectively. The flag shows after exactly three rising edges from the pin change.
- R4: `status[2]` is set only when the effective ring level falls from 1 to 0, that is, when `ri_n` goes from low to high. A high-to-low `ri_n` does not set it.
- R5: Set flags stay set while `rd_stb` is low. A rising edge with `rd_stb` high clears every flag that has no new change at that edge.
- R6: A change detected at the same edge as the read leaves its flag set.
- R7: With `loop_en` high, the pins are ignored and `status[7:4]` equals `{out2, out1, dtr, rts}`. This holds in the same cycle, with no register on the way.
- R8: With `loop_en` high, a change of `rts`, `dtr` or `out2` sets flag 0, 1 or 3 at the next edge. A 1-to-0 fall of `out1` sets flag 2 at the next edge, and a 0-to-1 rise of `out1` does not.
- R9: Toggling `loop_en` sets, at the next edge, the flag of every line whose effective value differs between the two sources, subject to the rule of R4 for line 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cts_n | input | 1 | Clear-to-send pin, active low, asynchronous |
| dsr_n | input | 1 | Data-set-ready pin, active low, asynchronous |
| ri_n | input | 1 | Ring indicator pin, active low, asynchronous |
| dcd_n | input | 1 | Carrier detect pin, active low, asynchronous |
| dtr | input | 1 | Data-terminal-ready control output of the port |
| rts | input | 1 | Request-to-send control output of the port |
| out1 | input | 1 | Internal general output 1 of the port |
| out2 | input | 1 | Internal general output 2 of the port |
| loop_en | input | 1 | Internal loopback mode select |
| rd_stb | input | 1 | One-cycle strobe marking a host read of the status byte |
| status | output | 8 | Change flags [3:0] and line levels [7:4] |

## Verification
A pin level is due two rising edges after the pin moves, and the matching change flag is due one edge after that. A loopback level is due in the same cycle as the control input or `loop_en` moves, and its flag is due one edge later. A read takes effect at the edge where `rd_stb` is high. The bench changes inputs on falling edges and samples on falling edges. Each check waits an exact count of rising edges, so it also catches a level that appears one cycle early, such as the one-edge check in the level test. The read-collision test raises the strobe exactly at the edge where a synchronized change is first compared.

// File: rtl/msr_pkg.sv
`timescale 1ns/1ps
// Package: shared line indices, vector type and edge-mode mask for the
// modem status register. Assumes four modem lines in a fixed bit order,
// which the host software decodes.
package msr_pkg;
    localparam int NLINES = 4;
    localparam int LN_CTS = 0;
    localparam int LN_DSR = 1;
    localparam int LN_RI  = 2;
    localparam int LN_DCD = 3;

    typedef logic [NLINES-1:0] line_vec_t;

    // Lines whose flag reacts only to a 1-to-0 fall of the asserted level.
    localparam line_vec_t TRAIL_ONLY_MASK = line_vec_t'(1) << LN_RI;
endpackage

// File: rtl/msr_sync.sv
`timescale 1ns/1ps
// Module: msr_sync
// Multi-stage synchronizer for a vector of asynchronous pins.
// Assumes: STAGES >= 1. During reset every stage loads the raw pin, so
// no phantom transition is seen when reset is released.
module msr_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    // Shift the pins through the stage chain; preload with raw pins in reset.
    always_ff @(posedge clk) begin
        for (int s = 0; s < STAGES; s++) begin
            if (!rst_n || s == 0) begin
                stage_q[s] <= d_i;
            end else begin
                stage_q[s] <= stage_q[(s > 0) ? s - 1 : 0];
            end
        end
    end

    assign q_o = stage_q[LAST];
endmodule

// File: rtl/msr_src_sel.sv
`timescale 1ns/1ps
// Module: msr_src_sel
// Chooses the effective active-high line levels: inverted synchronized
// pins in normal mode, the port's own control outputs in loopback.
// Also gives the preload value used in reset, built from raw pins.
// Assumes ctrl_i is already in line order (rts, dtr, out1, out2).
module msr_src_sel
    import msr_pkg::*;
(
    input  logic      loop_i,
    input  line_vec_t pin_n_sync_i,
    input  line_vec_t pin_n_raw_i,
    input  line_vec_t ctrl_i,
    output line_vec_t eff_o,
    output line_vec_t preload_o
);
    // Effective level seen by the status byte and the delta logic.
    always_comb begin
        eff_o = loop_i ? ctrl_i : ~pin_n_sync_i;
    end

    // Level to seed the previous-value state while reset is held.
    always_comb begin
        preload_o = loop_i ? ctrl_i : ~pin_n_raw_i;
    end
endmodule

// File: rtl/msr_delta.sv
`timescale 1ns/1ps
// Module: msr_delta
// Sticky change detection per line. Each line keeps its previous level.
// A line in TRAIL_ONLY flags only a 1-to-0 fall, the others flag any
// change. The read strobe clears flags, but a change at the same edge wins.
// Assumes lvl_i is synchronous to clk.
module msr_delta #(
    parameter int               WIDTH      = 4,
    parameter logic [WIDTH-1:0] TRAIL_ONLY = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl_i,
    input  logic [WIDTH-1:0] preload_i,
    input  logic             rd_stb_i,
    output logic [WIDTH-1:0] flags_o
);
    logic [WIDTH-1:0] prev_q;
    logic [WIDTH-1:0] hit;
    logic [WIDTH-1:0] flag_q;

    // Remember last cycle's level; seed from the effective inputs in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= preload_i;
        end else begin
            prev_q <= lvl_i;
        end
    end

    // Per-line event detector: trailing-only or any-edge, chosen per bit.
    for (genvar i = 0; i < WIDTH; i++) begin : g_line
        if (TRAIL_ONLY[i]) begin : g_trail
            assign hit[i] = prev_q[i] & ~lvl_i[i];

            // R4: with no fall and no earlier flag, the flag stays clear
            a_r4_trailing_only : assert property (@(posedge clk) disable iff (!rst_n)
                (!flag_q[i] && !(prev_q[i] && !lvl_i[i])) |=> !flag_q[i]);
        end else begin : g_any
            assign hit[i] = prev_q[i] ^ lvl_i[i];
        end
    end

    // Sticky flags: clear on read, set on any event (event has priority).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            flag_q <= (flag_q & ~{WIDTH{rd_stb_i}}) | hit;
        end
    end

    assign flags_o = flag_q;

    // R5: without a read, no set flag is lost
    a_r5_sticky : assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb_i |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

    // R5: after a read only lines with an event at that edge remain flagged
    a_r5_read_clears : assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb_i |=> ((flag_q & ~$past(hit)) == '0));

    // R6: an event coinciding with a read keeps its flag
    a_r6_keep_on_collision : assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb_i && (hit != '0)) |=> ((flag_q & $past(hit)) == $past(hit)));
endmodule

// File: rtl/modem_status_unit.sv
`timescale 1ns/1ps
// Module: modem_status_unit
// Modem status byte of a serial port: line levels in [7:4], sticky change
// flags in [3:0]. In loopback the levels follow the port's control outputs.
// Assumes the pins are asynchronous and the control outputs and rd_stb
// are synchronous to clk. Interrupt generation is done elsewhere.
module modem_status_unit
    import msr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cts_n,
    input  logic       dsr_n,
    input  logic       ri_n,
    input  logic       dcd_n,
    input  logic       dtr,
    input  logic       rts,
    input  logic       out1,
    input  logic       out2,
    input  logic       loop_en,
    input  logic       rd_stb,
    output logic [7:0] status
);
    line_vec_t pin_raw_n;
    line_vec_t pin_sync_n;
    line_vec_t ctrl_vec;
    line_vec_t eff_lvl;
    line_vec_t preload_lvl;
    line_vec_t flags;

    // Gather pins and control outputs into line order.
    always_comb begin
        pin_raw_n         = '0;
        pin_raw_n[LN_CTS] = cts_n;
        pin_raw_n[LN_DSR] = dsr_n;
        pin_raw_n[LN_RI]  = ri_n;
        pin_raw_n[LN_DCD] = dcd_n;
        ctrl_vec          = '0;
        ctrl_vec[LN_CTS]  = rts;
        ctrl_vec[LN_DSR]  = dtr;
        ctrl_vec[LN_RI]   = out1;
        ctrl_vec[LN_DCD]  = out2;
    end

    msr_sync #(
        .WIDTH  (NLINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_raw_n),
        .q_o   (pin_sync_n)
    );

    msr_src_sel u_src (
        .loop_i       (loop_en),
        .pin_n_sync_i (pin_sync_n),
        .pin_n_raw_i  (pin_raw_n),
        .ctrl_i       (ctrl_vec),
        .eff_o        (eff_lvl),
        .preload_o    (preload_lvl)
    );

    msr_delta #(
        .WIDTH      (NLINES),
        .TRAIL_ONLY (TRAIL_ONLY_MASK)
    ) u_delta (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl_i     (eff_lvl),
        .preload_i (preload_lvl),
        .rd_stb_i  (rd_stb),
        .flags_o   (flags)
    );

    // Assemble the status byte: levels high nibble, flags low nibble.
    always_comb begin
        status = {eff_lvl, flags};
    end

    // R7: in loopback the level nibble mirrors the control outputs
    a_r7_loop_map : assert property (@(posedge clk) disable iff (!rst_n)
        loop_en |-> (status[7:4] == {out2, out1, dtr, rts}));

    // R8: in loopback a change of rts always raises flag 0 next cycle
    a_r8_loop_rts_flag : assert property (@(posedge clk) disable iff (!rst_n)
        (loop_en && $past(loop_en) && $past(rst_n) && (rts != $past(rts))) |=> status[0]);
endmodule

// File: tb/test_modem_status_unit.sv
`timescale 1ns/1ps
// Directed bench for modem_status_unit. Inputs change on falling edges,
// outputs are sampled on falling edges after a counted number of rising edges.
module test_modem_status_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cts_n = 1'b0, dsr_n = 1'b1, ri_n = 1'b1, dcd_n = 1'b1;
    logic       dtr = 1'b0, rts = 1'b0, out1 = 1'b0, out2 = 1'b0;
    logic       loop_en = 1'b0, rd_stb = 1'b0;
    logic [7:0] status;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    modem_status_unit i_modem_status_unit (
        .clk(clk), .rst_n(rst_n), .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n),
        .dcd_n(dcd_n), .dtr(dtr), .rts(rts), .out1(out1), .out2(out2),
        .loop_en(loop_en), .rd_stb(rd_stb), .status(status)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] exp);
        total++;
        if (status !== exp) begin
            bad++;
            $display("FAIL %s: status=%02h expected=%02h", req, status, exp);
        end
    endtask

    task automatic host_read();
        rd_stb = 1'b1;
        tick(1);
        rd_stb = 1'b0;
    endtask

    task automatic t_reset();
        tick(4);
        rst_n = 1'b1;
        tick(1);
        chk("R1 reset state", 8'h10);
        tick(3);
        chk("R1 no spurious flag", 8'h10);
    endtask

    task automatic t_levels_deltas();
        cts_n = 1'b1;
        tick(1);
        chk("R2 level not yet after one edge", 8'h10);
        tick(1);
        chk("R2 level after two edges", 8'h00);
        tick(1);
        chk("R3 cts flag after three edges", 8'h01);
        dsr_n = 1'b0;
        dcd_n = 1'b0;
        tick(3);
        chk("R3 dsr and dcd flags", 8'hAB);
    endtask

    task automatic t_read_clear();
        tick(5);
        chk("R5 flags held without read", 8'hAB);
        host_read();
        chk("R5 read clears flags", 8'hA0);
    endtask

    task automatic t_ri_edge();
        ri_n = 1'b0;
        tick(3);
        chk("R4 falling ri_n sets no flag", 8'hE0);
        ri_n = 1'b1;
        tick(3);
        chk("R4 rising ri_n sets flag 2", 8'hA4);
        host_read();
        chk("R5 ri flag cleared", 8'hA0);
    endtask

    task automatic t_collision();
        cts_n = 1'b0;
        tick(3);
        chk("R3 cts falls sets flag", 8'hB1);
        dcd_n = 1'b1;
        tick(2);
        chk("R2 dcd level dropped", 8'h31);
        host_read();
        chk("R6 change at read edge kept", 8'h38);
        host_read();
        chk("R5 second read clears", 8'h30);
    endtask

    task automatic t_loop_map();
        rts = 1'b0; dtr = 1'b1; out1 = 1'b1; out2 = 1'b0;
        loop_en = 1'b1;
        #1;
        chk("R7 loop levels same cycle", 8'h60);
        tick(1);
        chk("R9 entering loop flags cts", 8'h61);
        host_read();
        cts_n = 1'b1; dcd_n = 1'b0; ri_n = 1'b0;
        tick(4);
        chk("R7 pins ignored in loop", 8'h60);
    endtask

    task automatic t_loop_deltas();
        rts = 1'b1;
        #1;
        chk("R7 rts drives bit 4", 8'h70);
        tick(1);
        chk("R8 rts change flag", 8'h71);
        out1 = 1'b0;
        tick(1);
        chk("R8 out1 fall sets flag 2", 8'h35);
        out2 = 1'b1;
        tick(1);
        chk("R8 out2 change flag", 8'hBD);
        host_read();
        out1 = 1'b1;
        tick(1);
        chk("R8 out1 rise sets no flag", 8'hF0);
    endtask

    task automatic t_switch_back();
        loop_en = 1'b0;
        #1;
        chk("R2 pin levels back", 8'hE0);
        tick(1);
        chk("R9 leaving loop flags cts", 8'hE1);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_levels_deltas();
                t_read_clear();
                t_ri_edge();
                t_collision();
                t_loop_map();
                t_loop_deltas();
                t_switch_back();
                done = 1'b1;
            end
            begin
                repeat (5000) @(posedge clk);
                if (!done) begin
                    total++;
                    bad++;
                    $display("FAIL watchdog: done=0 expected=1");
                end
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule